// File: doc/BRIEF.md
# Indirect Command-Word Register Bridge

This block lets a host reach the 8-bit register file of a serial-bus controller core through one 64-bit command register instead of a flat register map. The host writes a command word carrying a busy flag, a primary opcode, an optional secondary opcode, a direction flag and a data byte. The bridge then performs the internal access. That access takes a fixed, parameterised number of cycles. When it is done the bridge clears the busy flag, and for a read it places the fetched byte in the low byte of the same word. The host polls the command register until the flag drops.

A second 64-bit register, at its own offset, holds the core interrupt enable and the manual overrides for the data and clock lines. Both registers are read through a registered read port. The core is modelled as a small register file: clock high-period, data, control, clock-control, and a status register that reads as the idle code 0xF8. A reset command clears the writable core registers.

Top module: `csr_core_bridge`

## Requirements
- R1: After the synchronous active-high reset, both CSRs read 0, the override and interrupt-enable outputs are 0, and the clock-control output is 0.
- R2: A write to offset 0x00 with bit 63 set, made while bit 63 is clear, starts an access. Bit 63 reads 1 until the ACC_LAT-th rising edge after the write edge, where it clears. With ACC_LAT=4, back-to-back polls give four 1s and then a 0.
- R3: A write to offset 0x00 while bit 63 is set is ignored. The stored word is unchanged and bit 63 stays 1.
- R4: Primary opcode 4 in bits 60:57 accesses the clock high-period register for both write and read.
- R5: Primary opcode 6 hands the choice to the secondary opcode in bits 34:32. Code 1 accesses the data register and code 2 the control register.
- R6: Secondary code 3 writes the clock-control register, whose value appears on `clk_ctl_cfg`, and reads the status register, which holds 0xF8.
- R7: Secondary code 7 is a core reset. It clears the high-period, data, control and clock-control registers.
- R8: Bit 56 set makes the access a read. On completion bits 7:0 hold the register value and bits 62:8 keep the written value.
- R9: Any other opcode combination completes in the same time, changes no core register and returns 0 in bits 7:0 when it is a read.
- R10: A write to offset 0x10 stores only bit 6 (interrupt enable), bit 8 (data-line override) and bit 9 (clock-line override). The other bits read 0. The outputs follow on the write edge.
- R11: The offset-0x10 register can be written while a command is busy, and the busy command is not disturbed.
- R12: A write to offset 0x00 with bit 63 clear is stored as it is and starts no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_wr | input | 1 | CSR write strobe |
| csr_rd | input | 1 | CSR read strobe |
| csr_addr | input | 8 | CSR byte offset |
| csr_wdata | input | 64 | CSR write data |
| csr_rdata | output | 64 | CSR read data, registered |
| core_int_en | output | 1 | Core interrupt enable |
| sda_force | output | 1 | Data-line override |
| scl_force | output | 1 | Clock-line override |
| clk_ctl_cfg | output | 8 | Clock-control register contents |

## Verification
Read data is due one edge after the read strobe is sampled. A command's busy flag falls on the ACC_LAT-th edge after its write edge, so a poll issued right after the write sees exactly ACC_LAT busy reads. The bench counts those polls and compares the count with ACC_LAT+1. The override outputs and the clock-control output change on the edge that samples the write, or on the completion edge. All inputs are driven and all outputs sampled on the falling edge, half a cycle away from those edges.

// File: rtl/csr_bridge_pkg.sv
package csr_bridge_pkg;
  localparam int WORD_W   = 64;
  localparam int BYTE_W   = 8;
  localparam int BUSY_BIT = 63;
  localparam int RD_BIT   = 56;
  localparam int OP_LSB   = 57;
  localparam int OP_W     = 4;
  localparam int XOP_LSB  = 32;
  localparam int XOP_W    = 3;
  localparam int IEN_BIT  = 6;
  localparam int SDA_BIT  = 8;
  localparam int SCL_BIT  = 9;
  localparam logic [7:0] CMD_OFS   = 8'h00;
  localparam logic [7:0] INT_OFS   = 8'h10;
  localparam logic [7:0] IDLE_CODE = 8'hF8;

  typedef enum logic [2:0] {
    TGT_NONE, TGT_THP, TGT_DATA, TGT_CTL, TGT_CLKCTL, TGT_STAT, TGT_CRST
  } tgt_e;
endpackage

// File: rtl/cmd_decode.sv
module cmd_decode
  import csr_bridge_pkg::*;
(
  input  logic [WORD_W-1:0] cmd,
  output tgt_e              tgt,
  output logic              is_rd
);
  logic [OP_W-1:0]  op;
  logic [XOP_W-1:0] xop;

  always_comb begin
    op    = cmd[OP_LSB +: OP_W];
    xop   = cmd[XOP_LSB +: XOP_W];
    is_rd = cmd[RD_BIT];
    tgt   = TGT_NONE;
    if (op == OP_W'(4)) begin
      tgt = TGT_THP;
    end else if (op == OP_W'(6)) begin
      case (xop)
        3'd1:    tgt = TGT_DATA;
        3'd2:    tgt = TGT_CTL;
        3'd3:    tgt = is_rd ? TGT_STAT : TGT_CLKCTL;
        3'd7:    tgt = TGT_CRST;
        default: tgt = TGT_NONE;
      endcase
    end
  end
endmodule

// File: rtl/acc_seq.sv
module acc_seq #(
  parameter int ACC_LAT = 4,
  localparam int CNT_W  = $clog2(ACC_LAT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             done,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (start)        cnt <= CNT_W'(ACC_LAT);
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign done = (cnt == CNT_W'(1));
endmodule

// File: rtl/core_regfile.sv
module core_regfile
  import csr_bridge_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_en,
  input  tgt_e              tgt,
  input  logic              is_rd,
  input  logic [BYTE_W-1:0] wbyte,
  output logic [BYTE_W-1:0] rbyte,
  output logic [BYTE_W-1:0] clkctl_o
);
  logic [BYTE_W-1:0] thp_q, data_q, ctl_q, clkctl_q;
  logic              wr_ok, crst;

  assign wr_ok = acc_en && !is_rd;
  assign crst  = acc_en && (tgt == TGT_CRST);

  always_ff @(posedge clk) begin
    if (rst || crst) begin
      thp_q    <= '0;
      data_q   <= '0;
      ctl_q    <= '0;
      clkctl_q <= '0;
    end else if (wr_ok) begin
      case (tgt)
        TGT_THP:    thp_q    <= wbyte;
        TGT_DATA:   data_q   <= wbyte;
        TGT_CTL:    ctl_q    <= wbyte;
        TGT_CLKCTL: clkctl_q <= wbyte;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (tgt)
      TGT_THP:  rbyte = thp_q;
      TGT_DATA: rbyte = data_q;
      TGT_CTL:  rbyte = ctl_q;
      TGT_STAT: rbyte = IDLE_CODE;
      default:  rbyte = '0;
    endcase
  end

  assign clkctl_o = clkctl_q;
endmodule

// File: rtl/csr_core_bridge.sv
module csr_core_bridge
  import csr_bridge_pkg::*;
#(
  parameter int ACC_LAT = 4,
  parameter int ADDR_W  = 8,
  localparam int CNT_W  = $clog2(ACC_LAT + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csr_wr,
  input  logic              csr_rd,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic [WORD_W-1:0] csr_wdata,
  output logic [WORD_W-1:0] csr_rdata,
  output logic              core_int_en,
  output logic              sda_force,
  output logic              scl_force,
  output logic [BYTE_W-1:0] clk_ctl_cfg
);
  localparam logic [WORD_W-1:0] INT_MASK =
    (WORD_W'(1) << IEN_BIT) | (WORD_W'(1) << SDA_BIT) | (WORD_W'(1) << SCL_BIT);

  logic [WORD_W-1:0] cmd_q, int_q;
  logic              cmd_sel, int_sel, take, start, done, is_rd;
  logic [CNT_W-1:0]  seq_cnt;
  logic [BYTE_W-1:0] rbyte;
  tgt_e              tgt;

  assign cmd_sel = csr_wr && (csr_addr == ADDR_W'(CMD_OFS));
  assign int_sel = csr_wr && (csr_addr == ADDR_W'(INT_OFS));
  assign take    = cmd_sel && !cmd_q[BUSY_BIT];
  assign start   = take && csr_wdata[BUSY_BIT];

  cmd_decode u_dec (.cmd(cmd_q), .tgt(tgt), .is_rd(is_rd));

  acc_seq #(.ACC_LAT(ACC_LAT)) u_seq (
    .clk(clk), .rst(rst), .start(start), .done(done), .cnt(seq_cnt)
  );

  core_regfile u_core (
    .clk(clk), .rst(rst), .acc_en(done), .tgt(tgt), .is_rd(is_rd),
    .wbyte(cmd_q[BYTE_W-1:0]), .rbyte(rbyte), .clkctl_o(clk_ctl_cfg)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= '0;
    end else if (take) begin
      cmd_q <= csr_wdata;
    end else if (done) begin
      cmd_q[BUSY_BIT] <= 1'b0;
      if (is_rd) cmd_q[BYTE_W-1:0] <= rbyte;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          int_q <= '0;
    else if (int_sel) int_q <= csr_wdata & INT_MASK;
  end

  always_ff @(posedge clk) begin
    if (rst) csr_rdata <= '0;
    else if (csr_rd) begin
      if (csr_addr == ADDR_W'(CMD_OFS))      csr_rdata <= cmd_q;
      else if (csr_addr == ADDR_W'(INT_OFS)) csr_rdata <= int_q;
      else                                   csr_rdata <= '0;
    end
  end

  assign core_int_en = int_q[IEN_BIT];
  assign sda_force   = int_q[SDA_BIT];
  assign scl_force   = int_q[SCL_BIT];
endmodule

// File: rtl/csr_core_bridge_chk.sv
module csr_core_bridge_chk
  import csr_bridge_pkg::*;
#(
  parameter int ACC_LAT = 4,
  parameter int ADDR_W  = 8,
  parameter int CNT_W   = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              csr_wr,
  input logic [ADDR_W-1:0] csr_addr,
  input logic [WORD_W-1:0] csr_wdata,
  input logic [WORD_W-1:0] cmd_q,
  input logic              core_int_en,
  input logic              sda_force,
  input logic              scl_force,
  input logic [CNT_W-1:0]  seq_cnt
);
  AST_RESET_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> (cmd_q == '0 && !core_int_en && !sda_force && !scl_force)); // R1

  AST_BUSY_WHILE_COUNT: assert property (@(posedge clk) disable iff (rst)
    (seq_cnt != '0) |-> cmd_q[BUSY_BIT]); // R2

  AST_START_LOADS_LAT: assert property (@(posedge clk) disable iff (rst)
    $rose(cmd_q[BUSY_BIT]) |-> (seq_cnt == CNT_W'(ACC_LAT))); // R2

  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (csr_wr && csr_addr == ADDR_W'(CMD_OFS) && seq_cnt > CNT_W'(1))
    |=> (cmd_q[BUSY_BIT] && $stable(cmd_q))); // R3

  AST_INT_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (rst)
    (csr_wr && csr_addr == ADDR_W'(INT_OFS))
    |=> (core_int_en == $past(csr_wdata[IEN_BIT]) && sda_force == $past(csr_wdata[SDA_BIT])
         && scl_force == $past(csr_wdata[SCL_BIT]))); // R10
endmodule

bind csr_core_bridge csr_core_bridge_chk #(
  .ACC_LAT(ACC_LAT), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
) i_chk (
  .clk(clk), .rst(rst), .csr_wr(csr_wr), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
  .cmd_q(cmd_q), .core_int_en(core_int_en), .sda_force(sda_force),
  .scl_force(scl_force), .seq_cnt(seq_cnt)
);

// File: tb/test_csr_core_bridge.sv
module test_csr_core_bridge;
  localparam int LAT = 4;
  logic        clk = 1'b0;
  logic        rst;
  logic        csr_wr, csr_rd;
  logic [7:0]  csr_addr;
  logic [63:0] csr_wdata, csr_rdata;
  logic        core_int_en, sda_force, scl_force;
  logic [7:0]  clk_ctl_cfg;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  csr_core_bridge #(.ACC_LAT(LAT)) i_csr_core_bridge (
    .clk(clk), .rst(rst), .csr_wr(csr_wr), .csr_rd(csr_rd), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .core_int_en(core_int_en),
    .sda_force(sda_force), .scl_force(scl_force), .clk_ctl_cfg(clk_ctl_cfg)
  );

  function automatic logic [63:0] mk(input logic [3:0] op, input logic [2:0] xop,
                                     input logic rd, input logic [7:0] b);
    logic [63:0] w = '0;
    w[63] = 1'b1; w[60:57] = op; w[56] = rd; w[34:32] = xop; w[7:0] = b;
    w[47:40] = 8'hA5;
    return w;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [63:0] d);
    @(negedge clk); csr_wr = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk); csr_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [63:0] d);
    csr_rd = 1'b1; csr_addr = a;
    @(negedge clk); d = csr_rdata; csr_rd = 1'b0;
  endtask

  // poll until busy clears; returns final word and poll count
  task automatic poll(output logic [63:0] d, output int n);
    n = 0;
    do begin rd(8'h00, d); n++; end while (d[63] && n < 100);
  endtask

  task automatic run(input logic [63:0] c, output logic [63:0] d);
    int n;
    wr(8'h00, c); poll(d, n);
  endtask

  task automatic t_reset;
    logic [63:0] d;
    rd(8'h00, d); check("R1 cmd", d, 0);
    rd(8'h10, d); check("R1 int", d, 0);
    check("R1 outs", {core_int_en, sda_force, scl_force, clk_ctl_cfg}, 0);
  endtask

  task automatic t_latency;
    logic [63:0] d, c; int n;
    c = mk(4'd4, 3'd0, 1'b0, 8'h33);
    wr(8'h00, c); poll(d, n);
    check("R2 poll count", 64'(n), 64'(LAT + 1));
    c[63] = 1'b0;
    check("R2 final word", d, c);
  endtask

  task automatic t_thp;
    logic [63:0] d;
    run(mk(4'd4, 3'd0, 1'b1, 8'h00), d);
    check("R4 thp read", 64'(d[7:0]), 64'h33);
    check("R8 upper kept", {d[62:8], 8'h0}, {mk(4'd4, 3'd0, 1'b1, 8'h00) & ~(64'h1 << 63)});
  endtask

  task automatic t_busy_ignore;
    logic [63:0] d, c; int n;
    c = mk(4'd6, 3'd1, 1'b0, 8'h5C);
    wr(8'h00, c);
    wr(8'h00, mk(4'd6, 3'd1, 1'b0, 8'hEE));
    rd(8'h00, d);
    check("R3 word kept while busy", d, c);
    poll(d, n);
    run(mk(4'd6, 3'd1, 1'b1, 8'h00), d);
    check("R3 data not overwritten", 64'(d[7:0]), 64'h5C);
    check("R5 data reg", 64'(d[7:0]), 64'h5C);
  endtask

  task automatic t_ctl_clk;
    logic [63:0] d;
    run(mk(4'd6, 3'd2, 1'b0, 8'h44), d);
    run(mk(4'd6, 3'd2, 1'b1, 8'h00), d);
    check("R5 ctl reg", 64'(d[7:0]), 64'h44);
    run(mk(4'd6, 3'd3, 1'b0, 8'h1A), d);
    check("R6 clkctl output", 64'(clk_ctl_cfg), 64'h1A);
    run(mk(4'd6, 3'd3, 1'b1, 8'h00), d);
    check("R6 status read", 64'(d[7:0]), 64'hF8);
  endtask

  task automatic t_unknown;
    logic [63:0] d; int n;
    wr(8'h00, mk(4'd2, 3'd1, 1'b0, 8'h99)); poll(d, n);
    check("R9 bad op time", 64'(n), 64'(LAT + 1));
    run(mk(4'd6, 3'd5, 1'b1, 8'h77), d);
    check("R9 bad xop read 0", 64'(d[7:0]), 64'h0);
    run(mk(4'd6, 3'd1, 1'b1, 8'h00), d);
    check("R9 data untouched", 64'(d[7:0]), 64'h5C);
  endtask

  task automatic t_no_valid;
    logic [63:0] d, c;
    c = mk(4'd6, 3'd1, 1'b0, 8'h01); c[63] = 1'b0;
    wr(8'h00, c); rd(8'h00, d);
    check("R12 stored", d, c);
    run(mk(4'd6, 3'd1, 1'b1, 8'h00), d);
    check("R12 no access", 64'(d[7:0]), 64'h5C);
  endtask

  task automatic t_int;
    logic [63:0] d, c;
    wr(8'h10, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(8'h10, d);
    check("R10 mask", d, 64'h340);
    check("R10 outs", {61'd0, core_int_en, sda_force, scl_force}, 64'h7);
    c = mk(4'd4, 3'd0, 1'b0, 8'h21);
    wr(8'h00, c);
    wr(8'h10, 64'h100);
    check("R11 outs while busy", {61'd0, core_int_en, sda_force, scl_force}, 64'h2);
    rd(8'h00, d);
    check("R11 cmd undisturbed", d, c);
  endtask

  task automatic t_crst;
    logic [63:0] d;
    run(mk(4'd6, 3'd7, 1'b0, 8'h00), d);
    check("R7 clkctl cleared", 64'(clk_ctl_cfg), 0);
    run(mk(4'd4, 3'd0, 1'b1, 8'h00), d);
    check("R7 thp cleared", 64'(d[7:0]), 0);
    run(mk(4'd6, 3'd1, 1'b1, 8'h00), d);
    check("R7 data cleared", 64'(d[7:0]), 0);
    run(mk(4'd6, 3'd2, 1'b1, 8'h00), d);
    check("R7 ctl cleared", 64'(d[7:0]), 0);
  endtask

  task automatic finish_up;
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    rst = 1'b1; csr_wr = 0; csr_rd = 0; csr_addr = 0; csr_wdata = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_latency;
    t_thp;
    t_busy_ignore;
    t_ctl_clk;
    t_unknown;
    t_no_valid;
    t_int;
    t_crst;
    finish_up;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_up;
  end
endmodule